// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a cycle-based, synthesizable stand-in for an 8K x 16 asynchronous static memory. A memory controller under test drives it the way it would drive a real part. There are three active-low control inputs: a chip select, an output gate and one write strobe per byte. Each of the two byte lanes is decoded on its own, and the result is one of four states: off, idle, writing or reading. Because the lanes are independent, a single access can write the low byte and read the high byte together, or the reverse.

A bidirectional pin has no clean synthesizable form. The model therefore brings out a 16-bit read-data bus and a per-lane drive flag instead. A lane that is not driving presents zeros on its slice of the read bus, so a surrounding bench can merge buses without contention. A write lands in storage on the rising clock edge on which its lane is in the writing state. The read path is combinational from the address, so read data is valid in the same cycle the address is applied. Storage is never cleared. A synchronous active-high reset only blocks writes and turns all drive flags off while it is held.

Top module: `dual_lane_sram`

## Requirements
- R1: While `ce_n` is 1, `drive` is 2'b00, `rdata` is 0 and no byte of storage changes, whatever `oe_n` and `wen` are.
- R2: With `ce_n`=0, `oe_n`=1 and `wen`=2'b00, the whole 16-bit `wdata` is stored at `addr` on the clock edge, and `drive` is 2'b00 in that cycle.
- R3: With `ce_n`=0 and `oe_n`=1, if exactly one bit of `wen` is 0, only that byte is stored: bit 0 selects `wdata[7:0]` and bit 1 selects `wdata[15:8]`. The other stored byte keeps its value, and `drive` is 2'b00.
- R4: With `ce_n`=0, `oe_n`=0 and `wen`=2'b10, byte 0 is written and `drive`=2'b10. In the same cycle, `rdata[15:8]` shows the stored high byte at `addr`.
- R5: With `ce_n`=0, `oe_n`=0 and `wen`=2'b01, byte 1 is written and `drive`=2'b01. In the same cycle, `rdata[7:0]` shows the stored low byte at `addr`.
- R6: With `ce_n`=0, `oe_n`=0 and `wen`=2'b11, `drive`=2'b11 and `rdata` equals the stored word at the current `addr` in the same cycle, with no clock edge in between.
- R7: A lane whose `drive` bit is 0 presents 8'h00 on its `rdata` slice.
- R8: A byte written on a clock edge is returned by a read of that address in the next cycle.
- R9: While `rst` is 1, `drive` is 2'b00 and no write reaches storage.
- R10: `addr` must not change between two consecutive cycles in which `ce_n` is 0 and some `wen` bit is 0. A write held over several cycles at one address stores the held data.
- R11: All 13 address bits are decoded, so address 0 and address 8191 are distinct words, and both are distinct from the words in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes and drive |
| addr | input | 13 | Word address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| wen | input | 2 | Active-low write strobes, bit i for byte lane i |
| wdata | input | 16 | Write data, byte lane i in bits 8i+7..8i |
| rdata | output | 16 | Read data; zero in lanes not driving |
| drive | output | 2 | Per-lane flag, 1 when that lane drives read data |

## Verification
A write to one lane and a read from the other can happen in the same access, and this is where the design is most likely to go wrong. The bench provokes it by lowering `oe_n` together with a single write strobe. It then checks two things in that cycle: that only the opposite lane drives, and that the driven lane shows the byte stored before the edge. After the edge it reads the full word back. That read-back must show the new byte in the written lane and the old byte in the other, which catches any cross-lane leak of write enable or output enable.

// File: rtl/dual_lane_sram_pkg.sv
package dual_lane_sram_pkg;

  // Per-lane access state after decoding the control inputs
  typedef enum logic [1:0] {
    LANE_OFF   = 2'd0,
    LANE_IDLE  = 2'd1,
    LANE_WRITE = 2'd2,
    LANE_READ  = 2'd3
  } lane_mode_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import dual_lane_sram_pkg::*;
(
  input  logic       rst,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       strobe_n,
  output lane_mode_e mode
);

  // The write strobe takes priority over the output gate within a lane
  always_comb begin
    if (rst || ce_n)   mode = LANE_OFF;
    else if (!strobe_n) mode = LANE_WRITE;
    else if (!oe_n)     mode = LANE_READ;
    else                mode = LANE_IDLE;
  end

endmodule

// File: rtl/lane_store.sv
module lane_store #(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wd,
  output logic [BYTE_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  // Not reset: contents are undefined until written
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wd;
  end

  assign rd = cells[addr];

endmodule

// File: rtl/dual_lane_sram.sv
module dual_lane_sram
  import dual_lane_sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce_n,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        wen,
  input  logic [LANES*BYTE_W-1:0] wdata,
  output logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES-1:0]        drive
);

  lane_mode_e lane_mode [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] stored;

    lane_decode u_dec (
      .rst      (rst),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .strobe_n (wen[g]),
      .mode     (lane_mode[g])
    );

    lane_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
      .clk  (clk),
      .we   (lane_mode[g] == LANE_WRITE),
      .addr (addr),
      .wd   (wdata[g*BYTE_W +: BYTE_W]),
      .rd   (stored)
    );

    assign drive[g] = (lane_mode[g] == LANE_READ);
    assign rdata[g*BYTE_W +: BYTE_W] = drive[g] ? stored : '0;
  end

endmodule

// File: rtl/dual_lane_sram_chk.sv
module dual_lane_sram_chk #(
  parameter int ADDR_W = 13,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       addr,
  input logic                    ce_n,
  input logic                    oe_n,
  input logic [LANES-1:0]        wen,
  input logic [LANES*BYTE_W-1:0] wdata,
  input logic [LANES*BYTE_W-1:0] rdata,
  input logic [LANES-1:0]        drive
);

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> (drive == '0 && rdata == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> drive == '0);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !(&wen) && $past(!ce_n && !(&wen) && !rst)) |-> $stable(addr));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4
    drive_cond_chk: assert property (@(posedge clk) disable iff (rst)
      drive[g] |-> (!ce_n && !oe_n && wen[g]));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !drive[g] |-> rdata[g*BYTE_W +: BYTE_W] == '0);

    // R8
    write_read_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!ce_n && !wen[g] && !rst) && drive[g] && addr == $past(addr))
        |-> rdata[g*BYTE_W +: BYTE_W] == $past(wdata[g*BYTE_W +: BYTE_W]));
  end

endmodule

bind dual_lane_sram dual_lane_sram_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .wen(wen), .wdata(wdata), .rdata(rdata), .drive(drive)
);

// File: tb/sim_dual_lane_sram.sv
`timescale 1ns/1ps
module sim_dual_lane_sram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [1:0]  wen = 2'b11;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  drive;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_lane_sram u0 (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .wen(wen), .wdata(wdata), .rdata(rdata), .drive(drive)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_n = 1'b1; oe_n = 1'b1; wen = 2'b11;
  endtask

  // One write cycle followed by an idle cycle
  task automatic do_write(input logic [12:0] a, input logic [15:0] d, input logic [1:0] w,
                          input string req);
    @(negedge clk);
    addr = a; wdata = d; wen = w; ce_n = 1'b0; oe_n = 1'b1;
    #1 chk({req, " drive during write"}, {14'd0, drive}, 16'h0000);
    @(negedge clk);
    go_idle();
  endtask

  task automatic do_read(input logic [12:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; wen = 2'b11;
    #1 chk({req, " read data"}, rdata, exp);
    chk({req, " read drive"}, {14'd0, drive}, 16'h0003);
    @(negedge clk);
    go_idle();
  endtask

  task automatic t_reset();
    // R9 R7: during reset nothing drives even with read controls active
    @(negedge clk);
    addr = 13'h0010; ce_n = 1'b0; oe_n = 1'b0; wen = 2'b11;
    #1 chk("R9 drive in reset", {14'd0, drive}, 16'h0000);
    chk("R7 rdata in reset", rdata, 16'h0000);
    @(negedge clk);
    go_idle();
    rst = 1'b0;
  endtask

  task automatic t_word_write();
    do_write(13'h0010, 16'hA1B2, 2'b00, "R2");
    do_read(13'h0010, 16'hA1B2, "R2 R6");
  endtask

  task automatic t_byte_write();
    do_write(13'h0010, 16'h33CC, 2'b10, "R3");
    do_read(13'h0010, 16'hA1CC, "R3 low byte only");
    do_write(13'h0010, 16'h5566, 2'b01, "R3");
    do_read(13'h0010, 16'h55CC, "R3 high byte only");
  endtask

  task automatic t_mixed_low_write();
    @(negedge clk);
    addr = 13'h0010; wdata = 16'h0077; ce_n = 1'b0; oe_n = 1'b0; wen = 2'b10;
    #1 chk("R4 drive", {14'd0, drive}, 16'h0002);
    chk("R4 R7 rdata old high byte", rdata, 16'h5500);
    @(negedge clk);
    go_idle();
    do_read(13'h0010, 16'h5577, "R8 after R4");
  endtask

  task automatic t_mixed_high_write();
    @(negedge clk);
    addr = 13'h0010; wdata = 16'h8800; ce_n = 1'b0; oe_n = 1'b0; wen = 2'b01;
    #1 chk("R5 drive", {14'd0, drive}, 16'h0001);
    chk("R5 R7 rdata old low byte", rdata, 16'h0077);
    @(negedge clk);
    go_idle();
    do_read(13'h0010, 16'h8877, "R8 after R5");
  endtask

  task automatic t_deselect();
    @(negedge clk);
    addr = 13'h0010; wdata = 16'hFFFF; ce_n = 1'b1; oe_n = 1'b0; wen = 2'b00;
    #1 chk("R1 drive", {14'd0, drive}, 16'h0000);
    chk("R1 rdata", rdata, 16'h0000);
    @(negedge clk);
    go_idle();
    do_read(13'h0010, 16'h8877, "R1 storage untouched");
  endtask

  task automatic t_address_ends();
    do_write(13'h0000, 16'h1234, 2'b00, "R11");
    do_write(13'h1FFF, 16'hFEDC, 2'b00, "R11");
    do_read(13'h0000, 16'h1234, "R11 bottom");
    do_read(13'h1FFF, 16'hFEDC, "R11 top");
    do_read(13'h0010, 16'h8877, "R11 middle");
  endtask

  task automatic t_same_cycle_read();
    // R6: consecutive reads with the address changing each cycle
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; wen = 2'b11; addr = 13'h0000;
    #1 chk("R6 addr 0", rdata, 16'h1234);
    @(negedge clk);
    addr = 13'h1FFF;
    #1 chk("R6 addr top", rdata, 16'hFEDC);
    @(negedge clk);
    go_idle();
  endtask

  task automatic t_held_write();
    @(negedge clk);
    addr = 13'h0020; wdata = 16'h4242; ce_n = 1'b0; oe_n = 1'b1; wen = 2'b00;
    @(negedge clk);
    @(negedge clk);
    go_idle();
    do_read(13'h0020, 16'h4242, "R10 held write");
  endtask

  task automatic t_reset_blocks_write();
    @(negedge clk);
    rst = 1'b1;
    addr = 13'h0010; wdata = 16'h0000; ce_n = 1'b0; oe_n = 1'b0; wen = 2'b00;
    #1 chk("R9 drive mid reset", {14'd0, drive}, 16'h0000);
    @(negedge clk);
    go_idle();
    rst = 1'b0;
    do_read(13'h0010, 16'h8877, "R9 write blocked");
  endtask

  initial begin
    t_reset();
    t_word_write();
    t_byte_write();
    t_mixed_low_write();
    t_mixed_high_write();
    t_deselect();
    t_address_ends();
    t_same_cycle_read();
    t_held_write();
    t_reset_blocks_write();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule